// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block is the issue stage in front of four functional pipelines that take different numbers of cycles: a single-cycle integer unit, a two-cycle floating-point adder, a five-cycle multiplier and a three-cycle load/store unit. It takes one register-to-register instruction per cycle over a valid/ready handshake, strictly in program order. An instruction is held at the head, and so holds back everything behind it, while any of four checks fails: the target unit is occupied, a source is still being produced, the destination is still pending from an older writer, or an in-flight store has yet to read the destination.

A per-register table holds a pending bit and the class of the unit that will write the register. Each unit is a tagged countdown that raises its own writeback strobe with the destination register in its final cycle. The matching pending bit clears on that clock edge. Several units may finish in the same cycle, and each has its own writeback port.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset no register is pending, no writeback strobe is high, and `in_ready` is high for any instruction.
- R2: The class codes are 0 integer, 1 adder, 2 multiplier and 3 load/store, with latencies 1, 2, 5 and 3. Suppose an instruction of class c is accepted at clock edge k. Then `wb_valid[c]` is high in the cycle after edge k+L-1, and `wb_dst` slice c (bits c*5 upward) carries the instruction's destination.
- R3: A unit accepts a new instruction only in the final cycle of the one it holds. Two instructions of the same class are therefore accepted at least L edges apart. Instructions of different classes may overlap.
- R4: An instruction whose source is pending is held. Its producer was accepted at edge k with latency L, so the earliest acceptance is edge k+L+1.
- R5: An instruction whose destination is pending is held until that write completes. Its earliest acceptance is edge k+L+1. Each register's last writeback comes from its last writer in program order.
- R6: The load/store unit reads its second source in its final cycle. An instruction whose destination equals that register is held until the store is in its final cycle, which is edge k+3 for a store accepted at edge k.
- R7: Issue is in program order. A held instruction keeps `in_ready` low and blocks all younger instructions. With no hazard, one instruction is accepted per cycle.
- R8: Writebacks from several units in the same cycle are all accepted, and all their pending bits clear on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head instruction present |
| in_cls | input | 2 | Unit class of the head instruction |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register (store data for load/store) |
| in_ready | output | 1 | High when the head instruction has no hazard |
| wb_valid | output | 4 | Writeback strobe per unit, indexed by class code |
| wb_dst | output | 20 | Destination register per unit, 5 bits each |

## Verification
The assertions assume that the instruction fields stay stable while `in_valid` is high and `in_ready` is low. The stimulus meets this because it changes fields only just after an accepting edge. The assertions also assume that only the design issues into the units. Random programs keep registers within a small set of eight so that read-after-write, write-after-write and store-data conflicts are frequent. Directed sequences pin down the coincident writeback and store-data cases. The bench model handles one instruction at a time and predicts every acceptance edge and writeback cycle from the latencies alone.

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
  parameter int NREG      = 32,
  parameter int INT_LAT   = 1,
  parameter int FADD_LAT  = 2,
  parameter int FMUL_LAT  = 5,
  parameter int LDST_LAT  = 3,
  localparam int RW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_cls,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src1,
  input  logic [RW-1:0] in_src2,
  output logic          in_ready,
  output logic [3:0]    wb_valid,
  output logic [4*RW-1:0] wb_dst
);
  localparam int NU   = 4;
  localparam int M01  = (INT_LAT > FADD_LAT) ? INT_LAT : FADD_LAT;
  localparam int M23  = (FMUL_LAT > LDST_LAT) ? FMUL_LAT : LDST_LAT;
  localparam int MAXL = (M01 > M23) ? M01 : M23;
  localparam int CW   = $clog2(MAXL + 1);

  function automatic int lat_of(int u);
    case (u)
      0: return INT_LAT;
      1: return FADD_LAT;
      2: return FMUL_LAT;
      default: return LDST_LAT;
    endcase
  endfunction

  logic [NREG-1:0] pend, clr;
  logic [1:0]      owner [NREG];
  logic [CW-1:0]   cnt   [NU];
  logic [RW-1:0]   udst  [NU];
  logic [RW-1:0]   st_src;

  wire fire   = in_valid & in_ready;
  wire busy   = cnt[in_cls] > CW'(1);
  wire raw    = pend[in_src1] | pend[in_src2];
  wire waw    = pend[in_dst];
  wire war    = (cnt[3] > CW'(1)) && (st_src == in_dst);

  assign in_ready = !(busy | raw | waw | war);

  for (genvar u = 0; u < NU; u++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[u]  <= '0;
        udst[u] <= '0;
      end else if (fire && in_cls == 2'(u)) begin
        cnt[u]  <= CW'(lat_of(u));
        udst[u] <= in_dst;
      end else if (cnt[u] != '0) begin
        cnt[u]  <= cnt[u] - CW'(1);
      end
    end
    assign wb_valid[u]           = (cnt[u] == CW'(1));
    assign wb_dst[u*RW +: RW]    = udst[u];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         st_src <= '0;
    else if (fire && in_cls == 2'd3)    st_src <= in_src2;
  end

  always_comb begin
    clr = '0;
    for (int r = 0; r < NREG; r++)
      for (int u = 0; u < NU; u++)
        if (wb_valid[u] && udst[u] == RW'(r) && owner[r] == 2'(u)) clr[r] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      for (int r = 0; r < NREG; r++) owner[r] <= '0;
    end else begin
      pend <= (pend & ~clr) | (fire ? (NREG'(1) << in_dst) : '0);
      if (fire) owner[in_dst] <= in_cls;
    end
  end
endmodule

module scoreboard_chk #(
  parameter int RW       = 5,
  parameter int FMUL_LAT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    in_cls,
  input logic [RW-1:0] in_src1,
  input logic [RW-1:0] in_src2,
  input logic          in_ready,
  input logic [3:0]    wb_valid,
  input logic [4*RW-1:0] wb_dst
);
  logic [7:0] gap;
  logic       seen;
  wire mul_fire = in_valid && in_ready && in_cls == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= '0; seen <= 1'b0;
    end else if (mul_fire) begin
      gap <= 8'd1; seen <= 1'b1;
    end else if (gap != 8'hff) begin
      gap <= gap + 8'd1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> wb_valid == 4'b0);

  assert_mul_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_fire && seen) |-> gap >= 8'(FMUL_LAT));

  assert_adder_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid[1] |=> !wb_valid[1]);

  for (genvar u = 0; u < 4; u++) begin : g_raw
    assert_no_read_of_inflight_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wb_valid[u] &&
       (in_src1 == wb_dst[u*RW +: RW] || in_src2 == wb_dst[u*RW +: RW])) |-> !in_ready);
  end

  for (genvar u = 0; u < 4; u++) begin : g_waw_a
    for (genvar v = u + 1; v < 4; v++) begin : g_waw_b
      assert_distinct_writers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid[u] && wb_valid[v]) |-> wb_dst[u*RW +: RW] != wb_dst[v*RW +: RW]);
    end
  end
endmodule

bind issue_scoreboard scoreboard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
  .in_src1(in_src1), .in_src2(in_src2), .in_ready(in_ready),
  .wb_valid(wb_valid), .wb_dst(wb_dst)
);

// File: tb/sim_issue_scoreboard.sv
module sim_issue_scoreboard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_cls = '0;
  logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic in_ready;
  logic [3:0] wb_valid;
  logic [19:0] wb_dst;

  issue_scoreboard u0 (.*);

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int lat [4] = '{1, 2, 5, 3};
  int rr [32], warr [32], uf [4];
  int exp_last [32], last_wr [32];
  int busy_u [4], exp_wb [4], exp_dst [4], fl_idx [4];
  int prev, iss [5];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic do_wb();
    for (int u = 0; u < 4; u++) if (wb_valid[u]) begin
      if (busy_u[u] == 0) chk(0, "R2", u, -1);
      else begin
        chk(cyc == exp_wb[u], "R2", cyc, exp_wb[u]);
        chk(int'(wb_dst[u*5 +: 5]) == exp_dst[u], "R2", int'(wb_dst[u*5 +: 5]), exp_dst[u]);
        last_wr[wb_dst[u*5 +: 5]] = fl_idx[u];
        busy_u[u] = 0;
      end
    end
  endtask

  task automatic issue_one(input int c, input int d, input int s1, input int s2, input int idx);
    int e; string tag; int waited;
    e = prev + 1; tag = "R7";
    if (uf[c] > e) begin e = uf[c]; tag = "R3"; end
    if (rr[s1] > e) begin e = rr[s1]; tag = "R4"; end
    if (rr[s2] > e) begin e = rr[s2]; tag = "R4"; end
    if (rr[d] > e) begin e = rr[d]; tag = "R5"; end
    if (warr[d] > e) begin e = warr[d]; tag = "R6"; end
    in_valid = 1'b1; in_cls = 2'(c); in_dst = 5'(d); in_src1 = 5'(s1); in_src2 = 5'(s2);
    waited = 0;
    forever begin
      @(negedge clk);
      do_wb();
      if (in_ready) break;
      waited++;
      if (waited > 60) begin chk(0, "R7", cyc, e); in_valid = 1'b0; return; end
    end
    chk(cyc + 1 == e, tag, cyc + 1, e);
    if (idx < 5) iss[idx] = cyc + 1;
    busy_u[c] = 1; exp_wb[c] = e + lat[c] - 1; exp_dst[c] = d; fl_idx[c] = idx;
    prev = e;
    uf[c] = e + lat[c];
    rr[d] = e + lat[c] + 1;
    if (c == 3 && warr[s2] < e + lat[c]) warr[s2] = e + lat[c];
    exp_last[d] = idx;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) begin @(negedge clk); do_wb(); end
    @(posedge clk); #1;
    prev = cyc;
  endtask

  task automatic begin_prog();
    @(posedge clk); #1;
    prev = cyc;
  endtask

  initial begin
    int id;
    for (int r = 0; r < 32; r++) begin rr[r] = 0; warr[r] = 0; exp_last[r] = -1; last_wr[r] = -1; end
    for (int u = 0; u < 4; u++) begin uf[u] = 0; busy_u[u] = 0; end
    void'($urandom(32'd2417));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    in_cls = 2'd2; in_dst = 5'd31; in_src1 = 5'd30; in_src2 = 5'd29;
    @(negedge clk);
    chk(wb_valid == 4'b0, "R1", int'(wb_valid), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);

    begin_prog();
    issue_one(1, 10, 2, 4, 0);
    issue_one(2, 10, 10, 6, 1);
    issue_one(1, 12, 10, 8, 2);
    issue_one(1, 4, 4, 6, 3);
    issue_one(1, 10, 4, 8, 4);
    chk(iss[1] == iss[0] + 3, "R4", iss[1], iss[0] + 3);
    chk(iss[3] == iss[2] + 2, "R3", iss[3], iss[2] + 2);
    idle(12);
    chk(last_wr[10] == 4, "R5", last_wr[10], 4);

    begin_prog();
    id = 10;
    issue_one(2, 1, 3, 3, 0);
    issue_one(0, 9, 3, 3, 1);
    issue_one(0, 10, 3, 3, 2);
    issue_one(1, 2, 3, 3, 3);
    issue_one(0, 11, 1, 2, 4);
    chk(iss[4] == iss[0] + 6, "R8", iss[4], iss[0] + 6);
    idle(10);

    begin_prog();
    issue_one(3, 3, 1, 5, 20);
    issue_one(1, 5, 2, 2, 21);
    issue_one(2, 7, 2, 2, 22);
    issue_one(1, 7, 2, 2, 23);
    idle(12);
    chk(last_wr[5] == 21, "R6", last_wr[5], 21);
    chk(last_wr[7] == 23, "R5", last_wr[7], 23);

    for (int p = 0; p < 4; p++) begin
      begin_prog();
      for (int i = 0; i < 40; i++) begin
        issue_one(int'($urandom_range(3, 0)), int'($urandom_range(7, 0)),
                  int'($urandom_range(7, 0)), int'($urandom_range(7, 0)), 100 + p * 40 + i);
      end
      idle(12);
    end
    for (int r = 0; r < 32; r++)
      if (exp_last[r] >= 0) chk(last_wr[r] == exp_last[r], "R5", last_wr[r], exp_last[r]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL R7 watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule